// File: doc/BRIEF.md
# Global Lock and Drain Arbiter

This block is the shared-memory front end for a group of hardware threads. Each thread keeps its own FIFO store buffer. The block holds one global lock, which it hands to a single thread at a time so that the thread can run an atomic read-modify-write. In every cycle it also picks at most one thread whose oldest buffered store is written into the shared array, and at most one thread whose load is served from that array.

A thread asks for the lock with a target address. The locked operation is an atomic decrement. In the grant cycle the block reads the counter and returns the value minus one, together with a flag that is set when that result is non-negative. The thread then pushes the decremented value into its own buffer. The lock stays held until the owner asks to release it and its buffer reports empty. While the lock is held, every other thread is blocked: none of its loads or drains is granted.

Grants are combinational within the cycle of the request. Loads return data in that same cycle. Drain writes land at the next clock edge.

Top module: `glock_drain_arb`

## Requirements
- R1: After reset the lock is free, the owner index is 0, no grant is given unless a request is present, and every word of the shared array reads 0.
- R2: A lock grant is given only while no thread holds the lock, and only to a requester whose buffer reports empty. At most one lock grant is given per cycle.
- R3: Among simultaneous eligible lock requests, the winner is the first requester found scanning upward from a rotating pointer, wrapping from N-1 to 0. After each grant the pointer moves to the winner's index plus one.
- R4: In the lock grant cycle, rmw_val_o equals the word at the lock address minus one, modulo 2^DW. rmw_nonneg_o is 1 exactly when bit DW-1 of that result is 0.
- R5: From the cycle after a lock grant, lock_held_o is 1 and lock_owner_o is the winner's index. The owner index does not change while the lock stays held.
- R6: While the lock is held, drain grants and load grants go only to the owner. All other threads get none.
- R7: A held lock is freed at the edge after a cycle in which the owner asserts its unlock request and its buffer reports empty. An unlock request from a non-owner, or from the owner while its buffer is non-empty, has no effect. A new lock can be granted, at the earliest, in the cycle after the lock is freed.
- R8: In a cycle that carries a lock grant, no drain grant and no load grant is given to any thread.
- R9: A thread whose buffer reports non-empty presents its oldest entry as an address and data pair. At most one drain is granted per cycle, and the granted entry is written into the shared array at the next edge, so a load issued in a later cycle sees it.
- R10: Drain, load and lock grants among unblocked requesters rotate round-robin with the pointer placed after the winner. A request that stays present while its arbiter is open is granted within N such cycles.
- R11: At most one load is granted per cycle. In the grant cycle, ld_data_o equals the array word at that thread's load address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lock_req_i | input | N | Per-thread lock request |
| lock_addr_i | input | N*AW | Per-thread counter address for the atomic decrement |
| lock_gnt_o | output | N | One-hot lock grant, valid in the grant cycle |
| rmw_val_o | output | DW | Decremented counter value (valid with a lock grant) |
| rmw_nonneg_o | output | 1 | Decremented value is non-negative |
| unlock_req_i | input | N | Per-thread release request |
| buf_empty_i | input | N | Per-thread store buffer empty status; low means a drain is wanted |
| drain_addr_i | input | N*AW | Address of each buffer's oldest entry |
| drain_data_i | input | N*DW | Data of each buffer's oldest entry |
| drain_gnt_o | output | N | One-hot drain grant; the thread pops its oldest entry |
| ld_req_i | input | N | Per-thread load request |
| ld_addr_i | input | N*AW | Per-thread load address |
| ld_gnt_o | output | N | One-hot load grant |
| ld_data_o | output | DW | Load data for the granted thread |
| lock_held_o | output | 1 | Global lock is held |
| lock_owner_o | output | IW | Index of the current lock owner |

## Verification
The assertions assume that every input is a known value after reset, and that a thread reporting a non-empty buffer keeps a meaningful head entry on the drain address and data pins. The fairness bound assumes that a pending request is not withdrawn, because the per-thread wait count restarts whenever a request drops or its arbiter is closed. The stimulus draws every request, status, address and data bit fresh each cycle from a fixed-seed generator, and mixes in directed sequences for the counter values 1 and 0, for blocked accesses, for ignored releases and for lock contention among all threads. Since the block imposes no handshake obligation on its callers, any such pattern is legal input.

// File: rtl/gla_pkg.sv
package gla_pkg;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int wrap_next(input int i, input int n);
    return (i + 1 >= n) ? 0 : i + 1;
  endfunction

endpackage

// File: rtl/gla_rr_arb.sv
module gla_rr_arb #(
  parameter int N  = 4,
  parameter int IW = gla_pkg::idx_w(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);

  logic [IW-1:0] ptr_q;
  logic [IW-1:0] pick;
  logic          found;

  always_comb begin
    int j;
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < N; k++) begin
      j = int'(ptr_q) + k;
      if (j >= N) j -= N;
      if (!found && req_i[j]) begin
        found = 1'b1;
        pick  = IW'(j);
      end
    end
  end

  assign any_o = en_i && found;
  assign idx_o = pick;
  assign gnt_o = any_o ? (N'(1) << pick) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (any_o) ptr_q <= IW'(gla_pkg::wrap_next(int'(pick), N));
  end

  // per-lane wait count while open and pending, used by the bound check
  logic [IW:0] wait_q [N];

  for (genvar g = 0; g < N; g++) begin : g_wait
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) wait_q[g] <= '0;
      else if (!en_i || !req_i[g] || gnt_o[g]) wait_q[g] <= '0;
      else wait_q[g] <= wait_q[g] + 1'b1;
    end

    AST_RR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wait_q[g] < (IW+1)'(N)); // R10
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R9
  AST_GNT_IN_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0); // R10

endmodule

// File: rtl/gla_lock_ctrl.sv
module gla_lock_ctrl #(
  parameter int N  = 4,
  parameter int IW = gla_pkg::idx_w(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          gnt_any_i,
  input  logic [IW-1:0] gnt_idx_i,
  input  logic [N-1:0]  unlock_req_i,
  input  logic [N-1:0]  buf_empty_i,
  output logic          held_o,
  output logic [IW-1:0] owner_o
);

  logic          held_q;
  logic [IW-1:0] owner_q;
  logic          rel_ok;

  assign rel_ok = held_q && unlock_req_i[owner_q] && buf_empty_i[owner_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q  <= 1'b0;
      owner_q <= '0;
    end else if (gnt_any_i) begin
      held_q  <= 1'b1;
      owner_q <= gnt_idx_i;
    end else if (rel_ok) begin
      held_q  <= 1'b0;
    end
  end

  assign held_o  = held_q;
  assign owner_o = owner_q;

  AST_GNT_WHEN_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_any_i |-> !held_q); // R2
  AST_HELD_AFTER_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_any_i |=> held_q && owner_q == $past(gnt_idx_i)); // R5
  AST_OWNER_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_q && $past(held_q) |-> $stable(owner_q)); // R5
  AST_RELEASE_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(held_q) |-> $past(unlock_req_i[owner_q] && buf_empty_i[owner_q])); // R7

endmodule

// File: rtl/gla_shmem.sv
module gla_shmem #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i)); // R9

endmodule

// File: rtl/glock_drain_arb.sv
module glock_drain_arb #(
  parameter int N  = 4,
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int IW = gla_pkg::idx_w(N)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    lock_req_i,
  input  logic [N*AW-1:0] lock_addr_i,
  output logic [N-1:0]    lock_gnt_o,
  output logic [DW-1:0]   rmw_val_o,
  output logic            rmw_nonneg_o,
  input  logic [N-1:0]    unlock_req_i,
  input  logic [N-1:0]    buf_empty_i,
  input  logic [N*AW-1:0] drain_addr_i,
  input  logic [N*DW-1:0] drain_data_i,
  output logic [N-1:0]    drain_gnt_o,
  input  logic [N-1:0]    ld_req_i,
  input  logic [N*AW-1:0] ld_addr_i,
  output logic [N-1:0]    ld_gnt_o,
  output logic [DW-1:0]   ld_data_o,
  output logic            lock_held_o,
  output logic [IW-1:0]   lock_owner_o
);

  logic [AW-1:0] lk_addr [N];
  logic [AW-1:0] dr_addr [N];
  logic [DW-1:0] dr_data [N];
  logic [AW-1:0] rd_addr [N];

  for (genvar g = 0; g < N; g++) begin : g_unpk
    assign lk_addr[g] = lock_addr_i[g*AW +: AW];
    assign dr_addr[g] = drain_addr_i[g*AW +: AW];
    assign dr_data[g] = drain_data_i[g*DW +: DW];
    assign rd_addr[g] = ld_addr_i[g*AW +: AW];
  end

  logic          held;
  logic [IW-1:0] owner;
  logic [N-1:0]  owner_oh;
  logic [N-1:0]  pass_mask;
  logic          acc_open;

  logic          lk_any, dr_any, ld_any;
  logic [IW-1:0] lk_idx, dr_idx, ld_idx;
  logic [DW-1:0] rdata;

  assign owner_oh  = N'(1) << owner;
  assign pass_mask = held ? owner_oh : '1;
  // the lock grant cycle owns the read port and must see no competing write
  assign acc_open  = !lk_any;

  gla_rr_arb #(.N(N), .IW(IW)) u_lock_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (!held),
    .req_i  (lock_req_i & buf_empty_i),
    .gnt_o  (lock_gnt_o),
    .idx_o  (lk_idx),
    .any_o  (lk_any)
  );

  gla_rr_arb #(.N(N), .IW(IW)) u_drain_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (acc_open),
    .req_i  (~buf_empty_i & pass_mask),
    .gnt_o  (drain_gnt_o),
    .idx_o  (dr_idx),
    .any_o  (dr_any)
  );

  gla_rr_arb #(.N(N), .IW(IW)) u_load_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (acc_open),
    .req_i  (ld_req_i & pass_mask),
    .gnt_o  (ld_gnt_o),
    .idx_o  (ld_idx),
    .any_o  (ld_any)
  );

  gla_lock_ctrl #(.N(N), .IW(IW)) u_lock_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .gnt_any_i    (lk_any),
    .gnt_idx_i    (lk_idx),
    .unlock_req_i (unlock_req_i),
    .buf_empty_i  (buf_empty_i),
    .held_o       (held),
    .owner_o      (owner)
  );

  gla_shmem #(.AW(AW), .DW(DW)) u_shmem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (dr_any),
    .waddr_i (dr_addr[dr_idx]),
    .wdata_i (dr_data[dr_idx]),
    .raddr_i (lk_any ? lk_addr[lk_idx] : rd_addr[ld_idx]),
    .rdata_o (rdata)
  );

  assign rmw_val_o    = rdata - 1'b1;
  assign rmw_nonneg_o = ~rmw_val_o[DW-1];
  assign ld_data_o    = rdata;
  assign lock_held_o  = held;
  assign lock_owner_o = owner;

  AST_BLOCK_OTHERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_held_o |-> ((drain_gnt_o | ld_gnt_o) & ~(N'(1) << lock_owner_o)) == '0); // R6
  AST_QUIET_ON_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_gnt_o != '0) |-> (drain_gnt_o == '0 && ld_gnt_o == '0)); // R8
  AST_ONE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ld_gnt_o) <= 1); // R11
  AST_ONE_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lock_gnt_o)); // R2

endmodule

// File: tb/sim_glock_drain_arb.sv
module sim_glock_drain_arb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int IW = 2;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [N-1:0]    lock_req_i, unlock_req_i, buf_empty_i, ld_req_i;
  logic [N*AW-1:0] lock_addr_i, drain_addr_i, ld_addr_i;
  logic [N*DW-1:0] drain_data_i;
  logic [N-1:0]    lock_gnt_o, drain_gnt_o, ld_gnt_o;
  logic [DW-1:0]   rmw_val_o, ld_data_o;
  logic            rmw_nonneg_o, lock_held_o;
  logic [IW-1:0]   lock_owner_o;

  glock_drain_arb #(.N(N), .AW(AW), .DW(DW)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lock_req_i(lock_req_i), .lock_addr_i(lock_addr_i), .lock_gnt_o(lock_gnt_o),
    .rmw_val_o(rmw_val_o), .rmw_nonneg_o(rmw_nonneg_o),
    .unlock_req_i(unlock_req_i), .buf_empty_i(buf_empty_i),
    .drain_addr_i(drain_addr_i), .drain_data_i(drain_data_i), .drain_gnt_o(drain_gnt_o),
    .ld_req_i(ld_req_i), .ld_addr_i(ld_addr_i), .ld_gnt_o(ld_gnt_o), .ld_data_o(ld_data_o),
    .lock_held_o(lock_held_o), .lock_owner_o(lock_owner_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference state
  logic [DW-1:0] m_mem [1<<AW];
  bit m_held;
  int m_owner, m_lptr, m_dptr, m_rptr;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int pick(input logic [N-1:0] r, input int p);
    for (int k = 0; k < N; k++) begin
      int j;
      j = (p + k) % N;
      if (r[j]) return j;
    end
    return -1;
  endfunction

  function automatic logic [N-1:0] oh(input int w);
    return (w >= 0) ? (N'(1) << w) : '0;
  endfunction

  task automatic idle();
    lock_req_i = '0; unlock_req_i = '0; buf_empty_i = '1; ld_req_i = '0;
    lock_addr_i = '0; drain_addr_i = '0; drain_data_i = '0; ld_addr_i = '0;
  endtask

  // inputs already applied after a falling edge; checks, then the rising edge
  task automatic cycle();
    logic [N-1:0] mask;
    int lw, dw, rw;
    logic [DW-1:0] rv, exp_rmw;
    #1;
    mask = m_held ? oh(m_owner) : '1;
    lw = m_held ? -1 : pick(lock_req_i & buf_empty_i, m_lptr);
    dw = (lw >= 0) ? -1 : pick(~buf_empty_i & mask, m_dptr);
    rw = (lw >= 0) ? -1 : pick(ld_req_i & mask, m_rptr);
    chk(lock_held_o == m_held, "R5", "held", lock_held_o, m_held);
    if (m_held) chk(lock_owner_o == IW'(m_owner), "R5", "owner", lock_owner_o, m_owner);
    chk(lock_gnt_o == oh(lw), "R2/R3", "lock_gnt", lock_gnt_o, oh(lw));
    chk(drain_gnt_o == oh(dw), "R6/R8/R10", "drain_gnt", drain_gnt_o, oh(dw));
    chk(ld_gnt_o == oh(rw), "R6/R8/R11", "ld_gnt", ld_gnt_o, oh(rw));
    if (lw >= 0) begin
      rv = m_mem[lock_addr_i[lw*AW +: AW]];
      exp_rmw = rv - 1'b1;
      chk(rmw_val_o == exp_rmw, "R4", "rmw_val", rmw_val_o, exp_rmw);
      chk(rmw_nonneg_o == ~exp_rmw[DW-1], "R4", "nonneg", rmw_nonneg_o, ~exp_rmw[DW-1]);
    end
    if (rw >= 0) begin
      rv = m_mem[ld_addr_i[rw*AW +: AW]];
      chk(ld_data_o == rv, "R9/R11", "ld_data", ld_data_o, rv);
    end
    @(posedge clk_i);
    if (lw >= 0) begin
      m_held = 1'b1; m_owner = lw; m_lptr = (lw + 1) % N;
    end else if (m_held && unlock_req_i[m_owner] && buf_empty_i[m_owner]) begin
      m_held = 1'b0;
    end
    if (dw >= 0) begin
      m_mem[drain_addr_i[dw*AW +: AW]] = drain_data_i[dw*DW +: DW];
      m_dptr = (dw + 1) % N;
    end
    if (rw >= 0) m_rptr = (rw + 1) % N;
    @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int exp_w;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < (1 << AW); i++) m_mem[i] = '0;
    m_held = 1'b0; m_owner = 0; m_lptr = 0; m_dptr = 0; m_rptr = 0;
    idle();
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    // R1 reset state
    chk(lock_held_o == 1'b0, "R1", "held", lock_held_o, 0);
    chk(lock_owner_o == '0, "R1", "owner", lock_owner_o, 0);
    chk(lock_gnt_o == '0 && drain_gnt_o == '0 && ld_gnt_o == '0, "R1", "grants",
        lock_gnt_o | drain_gnt_o | ld_gnt_o, 0);
    rst_ni = 1'b1;

    // R1 array cleared
    idle(); ld_req_i[3] = 1'b1; ld_addr_i[3*AW +: AW] = 4'd9;
    #1 chk(ld_data_o == '0, "R1", "mem clear", ld_data_o, 0);
    cycle();

    // R9 drain then R11 load sees it
    idle(); buf_empty_i[0] = 1'b0; drain_addr_i[0 +: AW] = 4'd5; drain_data_i[0 +: DW] = 8'd1;
    #1 chk(drain_gnt_o == 4'b0001, "R9", "drain", drain_gnt_o, 1);
    cycle();
    idle(); ld_req_i[1] = 1'b1; ld_addr_i[1*AW +: AW] = 4'd5;
    #1 chk(ld_data_o == 8'd1, "R9", "drain visible", ld_data_o, 1);
    cycle();

    // R4 decrement 1 -> 0, non-negative
    idle(); lock_req_i[2] = 1'b1; lock_addr_i[2*AW +: AW] = 4'd5;
    ld_req_i = '1; buf_empty_i[0] = 1'b0;
    #1 chk(lock_gnt_o == 4'b0100, "R2", "lock grant", lock_gnt_o, 4);
    chk(rmw_val_o == 8'd0 && rmw_nonneg_o, "R4", "dec 1", {rmw_nonneg_o, rmw_val_o}, 9'h100);
    chk(drain_gnt_o == '0 && ld_gnt_o == '0, "R8", "quiet", drain_gnt_o | ld_gnt_o, 0);
    cycle();

    // R6 others blocked; owner writes back; R7 unlock with busy buffer ignored
    idle(); buf_empty_i = '0; ld_req_i = '1; unlock_req_i[2] = 1'b1;
    for (int t = 0; t < N; t++) begin
      drain_addr_i[t*AW +: AW] = 4'd7; drain_data_i[t*DW +: DW] = 8'hA0 + 8'(t);
      ld_addr_i[t*AW +: AW] = 4'd5;
    end
    drain_addr_i[2*AW +: AW] = 4'd5; drain_data_i[2*DW +: DW] = 8'd0;
    #1 chk(drain_gnt_o == 4'b0100, "R6", "drain owner only", drain_gnt_o, 4);
    chk(ld_gnt_o == 4'b0100, "R6", "load owner only", ld_gnt_o, 4);
    cycle();
    chk(lock_held_o == 1'b1, "R7", "busy unlock ignored", lock_held_o, 1);
    idle(); unlock_req_i[0] = 1'b1;
    cycle();
    chk(lock_held_o == 1'b1, "R7", "non-owner unlock ignored", lock_held_o, 1);
    idle(); unlock_req_i[2] = 1'b1; lock_req_i[3] = 1'b1;
    cycle();
    chk(lock_held_o == 1'b0, "R7", "release", lock_held_o, 0);

    // R4 decrement 0 -> all ones, negative
    idle(); lock_req_i[1] = 1'b1; lock_addr_i[1*AW +: AW] = 4'd5;
    #1 chk(rmw_val_o == 8'hFF && !rmw_nonneg_o, "R4", "dec 0", {rmw_nonneg_o, rmw_val_o}, 9'h0FF);
    cycle();
    idle(); unlock_req_i[1] = 1'b1;
    cycle();

    // R3 all threads contend; winners rotate from the pointer after thread 1
    exp_w = 2;
    for (int r = 0; r < N; r++) begin
      idle(); lock_req_i = '1; unlock_req_i = '1;
      #1 chk(lock_gnt_o == oh(exp_w), "R3", "rotation", lock_gnt_o, oh(exp_w));
      cycle();
      cycle();
      exp_w = (exp_w + 1) % N;
    end

    // constrained random traffic
    for (int c = 0; c < 4000; c++) begin
      for (int t = 0; t < N; t++) begin
        lock_req_i[t]   = ($urandom % 8) == 0;
        unlock_req_i[t] = ($urandom % 2) == 0;
        buf_empty_i[t]  = ($urandom % 2) == 0;
        ld_req_i[t]     = ($urandom % 2) == 0;
        lock_addr_i[t*AW +: AW]  = AW'($urandom % 4);
        drain_addr_i[t*AW +: AW] = AW'($urandom);
        ld_addr_i[t*AW +: AW]    = AW'($urandom);
        drain_data_i[t*DW +: DW] = ($urandom % 4 == 0) ? DW'($urandom % 3) : DW'($urandom);
      end
      cycle();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule